// File: doc/BRIEF.md
# Framed Counter Test-Sequence Generator

This block produces diagnostic test traffic in discrete frames on a streaming output. A one-cycle start request, accepted while the block is idle, launches one frame. Each frame is a run of words from a counter that begins at a start value captured in the accepting cycle. The first word is marked as start of packet and the last as end of packet. The frame length is a runtime input. A select input picks either a counting sequence or a constant sequence that repeats the start value. The select and the length are captured per frame.

The downstream side throttles emission with a ready input, and a word is emitted in the cycle after ready is seen high. The block raises its own request-ready output when it can take a new start request. Driving the start request from that output, or holding it high, gives frames with no idle cycle between them. A clock-enable input freezes all state while low. The synchronous reset has priority over the clock-enable.

Top module: `tsg_frame_gen`

## Requirements
- R1: A synchronous active-high reset, applied even mid-frame, leaves `out_valid`, `out_sop` and `out_eop` low and `req_ready` high, and no frame resumes afterwards.
- R2: When `req_ready` is high, a high `start_req` at a clock edge is accepted. If `out_ready` is also high at that edge, the first word appears with `out_valid` and `out_sop` high and `out_data` equal to `start_val`.
- R3: With `mode_sel` = 1 at acceptance, each valid word of a frame is exactly one more than the previous valid word, modulo 2^DATA_W.
- R4: The last word of a frame equals start value + length − 1 and carries `out_eop`. `req_ready` is low during the frame and is high again in the cycle that presents the eop word.
- R5: `out_sop` and `out_eop` are high only together with `out_valid`, and only on the first and the last word of a frame.
- R6: `start_val`, `frame_len` and `mode_sel` are sampled only at acceptance. Changing them during a frame leaves the frame unchanged.
- R7: A `start_req` held high yields back-to-back frames. Each new sop word follows the previous eop word in the very next cycle.
- R8: Driving `start_req` from `req_ready` also yields gap-free consecutive frames.
- R9: If `out_ready` is low at an enabled clock edge, `out_valid` is low in the following cycle. The sequence then resumes without skipping or repeating a value, including when the stall falls before the first or the last word.
- R10: A start request made while `req_ready` is low is ignored and is not queued.
- R11: While `clk_en` is low, every output holds its value.
- R12: A `frame_len` below 2 is treated as 2.
- R13: With `mode_sel` = 0 at acceptance, every word of the frame equals the captured start value. The sop and eop marks still sit on the first and last words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; low freezes all state |
| mode_sel | input | 1 | 1 = counting sequence, 0 = constant start value |
| frame_len | input | LEN_W | Words per frame, minimum 2 |
| start_val | input | DATA_W | First word of the next frame |
| start_req | input | 1 | Start request, sampled at clock edges |
| req_ready | output | 1 | High when a start request will be accepted |
| out_ready | input | 1 | Downstream ready; a word is emitted the cycle after it is high |
| out_data | output | DATA_W | Output word |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | First word of a frame |
| out_eop | output | 1 | Last word of a frame |

## Verification
The hardest case to reach from the ports is a frame boundary that coincides with a stall or a frozen clock. One example is a stall in the cycle just before the eop word, while the following frame is already being requested. Another is a stall in the very cycle that accepts a frame, so the sop word has to wait. The bench drives `out_ready`, `clk_en` and `start_req` from per-cycle tables. This places low cycles on exactly those edges. The expected stream is then rebuilt from the same table: a word is emitted for each cycle in which ready was high.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
    } mark_t;

endpackage

// File: rtl/tsg_frame_ctrl.sv
module tsg_frame_ctrl
    import tsg_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             start_req,
    input  logic             out_ready,
    input  logic [LEN_W-1:0] frame_len,
    output logic             busy,
    output logic             launch,
    output logic             emit,
    output logic             first_word,
    output logic             last_word
);

    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] idx;
    } ctrl_t;

    ctrl_t ctrl_q, ctrl_d;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] cur_idx;

    always_comb begin
        launch     = (ctrl_q.phase == PH_IDLE) && start_req;
        eff_len    = launch ? ((frame_len < MIN_LEN) ? MIN_LEN : frame_len) : ctrl_q.len;
        cur_idx    = launch ? '0 : ctrl_q.idx;
        emit       = ((ctrl_q.phase == PH_RUN) || launch) && out_ready;
        first_word = (cur_idx == '0);
        last_word  = (cur_idx == eff_len - 1'b1);

        ctrl_d = ctrl_q;
        if (launch) begin
            ctrl_d.phase = PH_RUN;
            ctrl_d.len   = eff_len;
            ctrl_d.idx   = '0;
        end
        if (emit) begin
            if (last_word) begin
                ctrl_d.phase = PH_IDLE;
                ctrl_d.idx   = '0;
            end else begin
                ctrl_d.idx = cur_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{phase: PH_IDLE, len: MIN_LEN, idx: '0};
        end else if (clk_en) begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy = (ctrl_q.phase == PH_RUN);

endmodule

// File: rtl/tsg_word_gen.sv
module tsg_word_gen #(
    parameter int DATA_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              launch,
    input  logic              emit,
    input  logic              count_mode,
    input  logic [DATA_W-1:0] start_val,
    output logic [DATA_W-1:0] word
);

    typedef struct packed {
        logic [DATA_W-1:0] nxt;
        logic              step;
    } gen_t;

    gen_t gen_q, gen_d;
    logic step_now;

    always_comb begin
        step_now   = launch ? count_mode : gen_q.step;
        word       = launch ? start_val : gen_q.nxt;
        gen_d.step = step_now;
        gen_d.nxt  = emit ? word + DATA_W'(step_now) : word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= '{nxt: '0, step: 1'b1};
        end else if (clk_en) begin
            gen_q <= gen_d;
        end
    end

endmodule

// File: rtl/tsg_out_stage.sv
module tsg_out_stage
    import tsg_pkg::*;
#(
    parameter int DATA_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              emit,
    input  logic              first_word,
    input  logic              last_word,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] out_data,
    output mark_t             out_mark
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        mark_t             mark;
    } ost_t;

    ost_t ost_q, ost_d;

    always_comb begin
        ost_d.data       = emit ? word : ost_q.data;
        ost_d.mark.valid = emit;
        ost_d.mark.sop   = emit && first_word;
        ost_d.mark.eop   = emit && last_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ost_q <= '{data: '0, mark: '{valid: 1'b0, sop: 1'b0, eop: 1'b0}};
        end else if (clk_en) begin
            ost_q <= ost_d;
        end
    end

    assign out_data = ost_q.data;
    assign out_mark = ost_q.mark;

endmodule

// File: rtl/tsg_frame_gen.sv
module tsg_frame_gen
    import tsg_pkg::*;
#(
    parameter int FRAME_LEN = 20,
    parameter int DATA_W    = $clog2(FRAME_LEN),
    parameter int LEN_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              mode_sel,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [DATA_W-1:0] start_val,
    input  logic              start_req,
    output logic              req_ready,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop
);

    logic              busy;
    logic              launch;
    logic              emit;
    logic              first_word;
    logic              last_word;
    logic [DATA_W-1:0] word;
    mark_t             mark;

    tsg_frame_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .start_req  (start_req),
        .out_ready  (out_ready),
        .frame_len  (frame_len),
        .busy       (busy),
        .launch     (launch),
        .emit       (emit),
        .first_word (first_word),
        .last_word  (last_word)
    );

    tsg_word_gen #(.DATA_W(DATA_W)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .launch     (launch),
        .emit       (emit),
        .count_mode (mode_sel),
        .start_val  (start_val),
        .word       (word)
    );

    tsg_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .emit       (emit),
        .first_word (first_word),
        .last_word  (last_word),
        .word       (word),
        .out_data   (out_data),
        .out_mark   (mark)
    );

    assign req_ready = !busy;
    assign out_valid = mark.valid;
    assign out_sop   = mark.sop;
    assign out_eop   = mark.eop;

endmodule

// File: rtl/tsg_checker.sv
module tsg_checker #(
    parameter int DATA_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en,
    input logic              mode_sel,
    input logic              start_req,
    input logic              req_ready,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_sop,
    input logic              out_eop
);

    logic [DATA_W-1:0] prev_q;
    logic              have_prev_q;
    logic              cnt_mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            cnt_mode_q  <= 1'b0;
        end else if (clk_en) begin
            if (out_valid) begin
                prev_q      <= out_data;
                have_prev_q <= 1'b1;
            end
            if (req_ready && start_req) begin
                cnt_mode_q <= mode_sel;
            end
        end
    end

    AST_SOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid); // R5
    AST_EOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> out_valid); // R5
    AST_STALL_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !out_ready) |=> !out_valid); // R9
    AST_LAUNCH_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (clk_en && req_ready && start_req) |=> !req_ready); // R10
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (clk_en && out_valid && !out_sop && cnt_mode_q && have_prev_q)
            |-> (out_data == DATA_W'(prev_q + 1'b1))); // R3
    AST_FROZEN_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(out_data) && $stable(out_valid) && $stable(req_ready))); // R11

endmodule

bind tsg_frame_gen tsg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .mode_sel  (mode_sel),
    .start_req (start_req),
    .req_ready (req_ready),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/tb_tsg_frame_gen.sv
module tb_tsg_frame_gen;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 5;
    localparam int LW  = 5;
    localparam int CYC = 128;

    logic          clk = 1'b0;
    logic          rst;
    logic          clk_en;
    logic          mode_sel;
    logic [LW-1:0] frame_len;
    logic [DW-1:0] start_val;
    logic          start_req;
    logic          req_ready;
    logic          out_ready;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          out_sop;
    logic          out_eop;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // per-cycle stimulus
    logic          drv_en[CYC], drv_mode[CYC], drv_start[CYC], drv_follow[CYC], drv_ready[CYC];
    logic [LW-1:0] drv_len[CYC];
    logic [DW-1:0] drv_sval[CYC];
    // recorded and expected outputs
    logic          rec_v[CYC], rec_s[CYC], rec_e[CYC], rec_r[CYC];
    logic [DW-1:0] rec_d[CYC];
    logic          exp_v[CYC], exp_s[CYC], exp_e[CYC];
    logic [DW-1:0] exp_d[CYC];

    always #(CLK_PERIOD/2) clk = ~clk;

    tsg_frame_gen #(.FRAME_LEN(20), .DATA_W(DW), .LEN_W(LW)) dut (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .mode_sel  (mode_sel),
        .frame_len (frame_len),
        .start_val (start_val),
        .start_req (start_req),
        .req_ready (req_ready),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    task automatic clear_tables();
        for (int i = 0; i < CYC; i++) begin
            drv_en[i] = 1'b1; drv_mode[i] = 1'b1; drv_start[i] = 1'b0;
            drv_follow[i] = 1'b0; drv_ready[i] = 1'b1;
            drv_len[i] = LW'(20); drv_sval[i] = DW'(2);
            exp_v[i] = 1'b0; exp_s[i] = 1'b0; exp_e[i] = 1'b0; exp_d[i] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; clk_en = 1'b1; start_req = 1'b0; out_ready = 1'b1;
        mode_sel = 1'b1; frame_len = LW'(20); start_val = DW'(2);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic record(input int i);
        rec_v[i] = out_valid; rec_s[i] = out_sop; rec_e[i] = out_eop;
        rec_d[i] = out_data;  rec_r[i] = req_ready;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) record(i - 1);
            clk_en    = drv_en[i];
            mode_sel  = drv_mode[i];
            frame_len = drv_len[i];
            start_val = drv_sval[i];
            out_ready = drv_ready[i];
            start_req = drv_follow[i] ? req_ready : drv_start[i];
        end
        @(negedge clk);
        record(n - 1);
        start_req = 1'b0;
    endtask

    task automatic put(input int c, input logic [DW-1:0] d, input logic s, input logic e);
        exp_v[c] = 1'b1; exp_d[c] = d; exp_s[c] = s; exp_e[c] = e;
    endtask

    task automatic exp_run(input int at, input int sv, input int len, input int step);
        for (int k = 0; k < len; k++) put(at + k, DW'(sv + k * step), k == 0, k == len - 1);
    endtask

    task automatic exp_gaps(input int at, input int sv, input int len);
        int c = at;
        int k = 0;
        while (k < len) begin
            if (drv_ready[c]) begin
                put(c, DW'(sv + k), k == 0, k == len - 1);
                k++;
            end
            c++;
        end
    endtask

    task automatic compare(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            total++;
            if ({rec_v[i], rec_s[i], rec_e[i]} !== {exp_v[i], exp_s[i], exp_e[i]} ||
                (exp_v[i] && rec_d[i] !== exp_d[i])) begin
                bad++;
                $display("FAIL %s cycle %0d: got v=%b d=%0d s=%b e=%b expected v=%b d=%0d s=%b e=%b",
                         tag, i, rec_v[i], rec_d[i], rec_s[i], rec_e[i],
                         exp_v[i], exp_d[i], exp_s[i], exp_e[i]);
            end
        end
    endtask

    task automatic check_bit(input logic got, input logic want, input string tag);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, got, want);
        end
    endtask

    // R1: reset mid-frame returns to idle
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R1 valid after reset");
        check_bit(req_ready, 1'b1, "R1 req_ready after reset");
        clear_tables();
        drv_start[0] = 1'b1;
        run(5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_bit(out_valid, 1'b0, "R1 valid after mid-frame reset");
        check_bit(out_sop,   1'b0, "R1 sop after mid-frame reset");
        check_bit(out_eop,   1'b0, "R1 eop after mid-frame reset");
        check_bit(req_ready, 1'b1, "R1 req_ready after mid-frame reset");
        clear_tables();
        run(6);
        compare(6, "R1 no resume");
    endtask

    // R2 R3 R4 R5 R6 R10: one frame, inputs changed mid-frame, extra start ignored
    task automatic t_single();
        do_reset();
        clear_tables();
        drv_start[0] = 1'b1;
        for (int i = 1; i < CYC; i++) drv_sval[i] = DW'(9);
        for (int i = 2; i < CYC; i++) drv_len[i] = LW'(3);
        for (int i = 3; i < CYC; i++) drv_mode[i] = 1'b0;
        drv_start[5] = 1'b1;
        exp_run(0, 2, 20, 1);
        run(30);
        compare(30, "R2 R3 R4 R5 R6 R10 single frame");
        check_bit(rec_r[10], 1'b0, "R4 req_ready low mid-frame");
        check_bit(rec_r[19], 1'b1, "R4 req_ready with eop");
        check_bit(rec_r[25], 1'b1, "R10 idle after ignored start");
    endtask

    // R7: start held high
    task automatic t_hold_start();
        do_reset();
        clear_tables();
        for (int i = 0; i < 60; i++) drv_start[i] = 1'b1;
        exp_run(0, 2, 20, 1);
        exp_run(20, 2, 20, 1);
        exp_run(40, 2, 20, 1);
        run(70);
        compare(70, "R7 back-to-back");
    endtask

    // R8: start driven from req_ready
    task automatic t_follow();
        do_reset();
        clear_tables();
        for (int i = 0; i <= 60; i++) drv_follow[i] = 1'b1;
        exp_run(0, 2, 20, 1);
        exp_run(20, 2, 20, 1);
        exp_run(40, 2, 20, 1);
        exp_run(60, 2, 20, 1);
        run(90);
        compare(90, "R8 follow ready");
    endtask

    // R9: stalls at acceptance, mid-frame and just before eop
    task automatic t_stall();
        do_reset();
        clear_tables();
        drv_start[0] = 1'b1;
        drv_ready[0] = 1'b0; drv_ready[5] = 1'b0; drv_ready[6] = 1'b0;
        drv_ready[19] = 1'b0; drv_ready[21] = 1'b0; drv_ready[22] = 1'b0;
        exp_gaps(0, 2, 20);
        run(40);
        compare(40, "R9 backpressure");
    endtask

    // R11: clock-enable low freezes outputs
    task automatic t_clken();
        do_reset();
        clear_tables();
        drv_start[0] = 1'b1;
        drv_en[3] = 1'b0; drv_en[4] = 1'b0;
        for (int k = 0; k < 3; k++) put(k, DW'(2 + k), k == 0, 1'b0);
        put(3, DW'(4), 1'b0, 1'b0);
        put(4, DW'(4), 1'b0, 1'b0);
        for (int k = 3; k < 20; k++) put(k + 2, DW'(2 + k), 1'b0, k == 19);
        run(30);
        compare(30, "R11 clock enable");
    endtask

    // R12 R3: short lengths clamped, counter wraps
    task automatic t_short();
        do_reset();
        clear_tables();
        for (int i = 0; i < 5; i++) drv_len[i] = LW'(1);
        for (int i = 5; i < 10; i++) begin drv_len[i] = LW'(0); drv_sval[i] = DW'(10); end
        for (int i = 10; i < CYC; i++) begin drv_len[i] = LW'(4); drv_sval[i] = DW'(30); end
        drv_start[0] = 1'b1; drv_start[5] = 1'b1; drv_start[10] = 1'b1;
        exp_run(0, 2, 2, 1);
        exp_run(5, 10, 2, 1);
        exp_run(10, 30, 4, 1);
        run(20);
        compare(20, "R12 R3 short and wrap");
    endtask

    // R13: constant mode, then counting mode
    task automatic t_const_mode();
        do_reset();
        clear_tables();
        for (int i = 0; i < 8; i++) drv_mode[i] = 1'b0;
        for (int i = 0; i < CYC; i++) begin drv_sval[i] = DW'(7); drv_len[i] = LW'(5); end
        drv_start[0] = 1'b1; drv_start[8] = 1'b1;
        exp_run(0, 7, 5, 0);
        exp_run(8, 7, 5, 1);
        run(20);
        compare(20, "R13 constant mode");
    endtask

    initial begin
        rst = 1'b1; clk_en = 1'b1; mode_sel = 1'b1; frame_len = LW'(20);
        start_val = DW'(2); start_req = 1'b0; out_ready = 1'b1;
        t_reset();
        t_single();
        t_hold_start();
        t_follow();
        t_stall();
        t_clken();
        t_short();
        t_const_mode();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule